// File: doc/BRIEF.md
# Supply Controller Serial Register Interface

This block is the serial control port of a power-supply controller for a satellite receiver front end. It is an I2C target that sits on the two open-drain bus lines. A host writes single bytes into it, and it presents the stored settings as plain control outputs: output enable, upper or lower voltage range, the one-volt step, tone enable, tone modulation source, decoder threshold, dynamic current limit and current-limit level. A host read returns a status byte built from five live fault inputs.

The device address has seven bits. The upper five bits are fixed at `00010`, and two strap pins supply the lowest two. There is no pointer byte. Instead, the top three bits of every written byte choose the register that its lower five bits go into, so one write transfer can update several registers in turn. The bus lines are oversampled by a fast system clock through a synchronizer and a glitch filter. A power-good input gates the whole port. While it is low the registers are held cleared, the outputs stay off, and the port never acknowledges.

Top module: `lnb_ctl_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal `0,0,0,1,0,dev_pin_a[1],dev_pin_a[0]` (MSB first). The eighth bit is the direction: 1 means read and 0 means write. A non-matching address gets no acknowledge, and the block ignores the rest of that transfer.
- R2: In a write, bits [7:5] of each data byte select the register: `001` is the tone register, `010` the limit register, `011` the output register. Any other value, including `000` (status), changes nothing. Every data byte is acknowledged.
- R3: Tone register fields: bit 4 drives `tone_on`, bit 3 drives `tone_mod_sel` and bit 2 drives `tone_thr_sel`. Bits 1:0 are ignored.
- R4: Limit register fields: bit 4 drives `ilim_dynamic`, bit 3 drives `vpin_sel_en` and bits 1:0 drive `ilim_code`. Bit 2 is ignored.
- R5: Output register fields: bit 4 drives `out_en`, bit 1 drives `vrange_hi` and bit 0 drives `vstep_up`. Bits 3:2 are ignored.
- R6: A read returns the byte `{3'b000, fault_flags}` MSB first. The `fault_flags` bits, from bit 4 down to bit 0, are over-temperature, cable open, output voltage out of range, overload and backward current. Each byte is sampled live when it starts. The block sends another byte after a master acknowledge and stops sending after a master not-acknowledge.
- R7: While `pwr_ok` is low, the block gives no acknowledge, ignores all bus traffic and holds every control output at 0. After `pwr_ok` rises, all outputs, `out_en` included, start at 0.
- R8: A write transfer may carry any number of data bytes. Each byte is decoded on its own by its select field, and later bytes take effect after earlier ones.
- R9: A START or STOP that arrives before the eighth bit of a byte ends that byte without a register change. After a START, the block expects a fresh address byte.
- R10: A pulse on SCL or SDA that is shorter than `GLITCH_CYC` system clocks is not seen by the protocol engine.
- R11: After reset, every control output is 0 and `sda_pull` is released (0).
- R12: The block changes its SDA drive only while SCL is low. Each acknowledge bit and each read-data bit is placed after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply good; low gates the port and clears registers |
| dev_pin_a | input | 2 | Strap pins giving the two low address bits |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| fault_flags | input | 5 | Live fault inputs returned by a read |
| tone_on | output | 1 | Tone enable |
| tone_mod_sel | output | 1 | Tone modulation source select |
| tone_thr_sel | output | 1 | Tone decoder threshold select |
| ilim_dynamic | output | 1 | Dynamic current-limit mode select |
| vpin_sel_en | output | 1 | Voltage select by pin enable |
| ilim_code | output | 2 | Current-limit level select |
| out_en | output | 1 | Supply output enable |
| vrange_hi | output | 1 | Upper voltage range select |
| vstep_up | output | 1 | One-volt step-up select |

## Verification
The hardest situations to reach from the ports are a bus condition that lands in the middle of a byte and a sub-threshold spike inside an otherwise valid bit. To reach the first, the bench cuts a byte off after four bits with a STOP, and separately with a repeated START followed by a full new transfer; it then checks that only the new byte took effect. To reach the second, it inserts short high pulses on SCL during each low phase of a write byte and compares the result with the byte the master intended. Randomized multi-byte writes with random select fields, and reads under random fault patterns, cover register decoding against a bench-side shadow model.

// File: rtl/lnbi2c_pkg.sv
// Shared types and constants for the supply-controller serial register port.
// Assumes a single-target bus with 7-bit addressing only.
package lnbi2c_pkg;

    // Fixed upper part of the device address; strap pins supply the low bits.
    localparam logic [4:0] DEV_ADDR_HI = 5'b00010;

    // Register select codes carried in bits [7:5] of a written byte.
    localparam logic [2:0] SEL_STATUS = 3'b000;
    localparam logic [2:0] SEL_TONE   = 3'b001;
    localparam logic [2:0] SEL_LIMIT  = 3'b010;
    localparam logic [2:0] SEL_OUTPUT = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in address or write data
        ST_ACK,    // driving acknowledge on ninth clock
        ST_TX,     // shifting out read data
        ST_MACK    // sampling master acknowledge
    } eng_state_t;

    typedef struct packed {
        logic       tone_on;
        logic       tone_mod_sel;
        logic       tone_thr_sel;
        logic       ilim_dynamic;
        logic       vpin_sel_en;
        logic [1:0] ilim_code;
        logic       out_en;
        logic       vrange_hi;
        logic       vstep_up;
    } ctl_fields_t;

endpackage

// File: rtl/lnbi2c_deglitch.sv
// Two-flop synchronizer plus pulse filter for one open-drain bus line.
// The clean level follows the synchronized input only after the input has
// disagreed with it for GLITCH_CYC consecutive clocks. Assumes the line idles high.
module lnbi2c_deglitch #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] dis_cnt;

    // Synchronize the line and qualify changes by a run-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            clean   <= 1'b1;
            dis_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                dis_cnt <= '0;
            end else if (dis_cnt == CW'(GLITCH_CYC - 1)) begin
                clean   <= sync_q[1];
                dis_cnt <= '0;
            end else begin
                dis_cnt <= dis_cnt + 1'b1;
            end
        end
    end

    AST_FILTER_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> (clean == $past(raw, 3))); // R10

endmodule

// File: rtl/lnbi2c_engine.sv
// Bus protocol engine working on filtered SCL/SDA levels. It detects START and
// STOP, matches the address, acknowledges, hands completed write bytes to the
// register file and serialises the status byte on reads.
// Assumes no clock stretching and that SCL is much slower than clk.
module lnbi2c_engine
    import lnbi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic [1:0] dev_pin_a,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] status_byte,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic [7:0] wr_byte
);
    localparam int BITS = 8;
    localparam int BCW  = $clog2(BITS + 1);

    eng_state_t     state;
    logic           scl_q, sda_q;
    logic [7:0]     rx_sh, tx_sh;
    logic [BCW-1:0] bit_cnt;
    logic           is_addr, rd_mode, m_acked;
    logic           scl_rise, scl_fall, bus_start, bus_stop;
    logic [6:0]     my_addr;

    // Edge and bus-condition decode from the previous filtered levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        bus_start = scl_f & scl_q & sda_q & ~sda_f;
        bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
        my_addr   = {DEV_ADDR_HI, dev_pin_a};
        wr_byte   = rx_sh;
    end

    // Register the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Main protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            bit_cnt  <= '0;
            is_addr  <= 1'b0;
            rd_mode  <= 1'b0;
            m_acked  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (!pwr_ok) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (bus_start) begin
                state    <= ST_RX;
                is_addr  <= 1'b1;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (bus_stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (scl_rise && bit_cnt != BCW'(BITS)) begin
                            rx_sh   <= {rx_sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == BCW'(BITS)) begin
                            if (is_addr) begin
                                if (rx_sh[7:1] == my_addr) begin
                                    sda_pull <= 1'b1;
                                    rd_mode  <= rx_sh[0];
                                    state    <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                wr_stb   <= 1'b1;
                                state    <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                tx_sh    <= status_byte;
                                sda_pull <= ~status_byte[7];
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                is_addr  <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BCW'(BITS)) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                tx_sh    <= {tx_sh[6:0], 1'b0};
                                sda_pull <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_acked <= ~sda_f;
                        end else if (scl_fall) begin
                            if (m_acked) begin
                                tx_sh    <= status_byte;
                                sda_pull <= ~status_byte[7];
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_NO_DRIVE_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sda_pull); // R7

    AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $past(pwr_ok) && scl_f && scl_q) |-> $stable(sda_pull)); // R12

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R8

endmodule

// File: rtl/lnbi2c_regs.sv
// Register file for the three writable control registers. A strobed byte is
// routed by its select field; unknown selects and the status select are dropped.
// All fields are held cleared while pwr_ok is low.
module lnbi2c_regs
    import lnbi2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_ok,
    input  logic        wr_stb,
    input  logic [7:0]  wr_byte,
    output ctl_fields_t fields
);
    logic [2:0] sel;
    assign sel = wr_byte[7:5];

    // Store the live fields of each register on a strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            fields <= '0;
        end else if (wr_stb) begin
            unique case (sel)
                SEL_TONE: begin
                    fields.tone_on      <= wr_byte[4];
                    fields.tone_mod_sel <= wr_byte[3];
                    fields.tone_thr_sel <= wr_byte[2];
                end
                SEL_LIMIT: begin
                    fields.ilim_dynamic <= wr_byte[4];
                    fields.vpin_sel_en  <= wr_byte[3];
                    fields.ilim_code    <= wr_byte[1:0];
                end
                SEL_OUTPUT: begin
                    fields.out_en    <= wr_byte[4];
                    fields.vrange_hi <= wr_byte[1];
                    fields.vstep_up  <= wr_byte[0];
                end
                default: ;
            endcase
        end
    end

    AST_CLEAR_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (fields == '0)); // R7

    AST_IGNORED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && wr_stb && (sel == SEL_STATUS || sel[2])) |=> $stable(fields)); // R2

endmodule

// File: rtl/lnb_ctl_i2c_slave.sv
// Top of the supply-controller serial register port. Filters both bus lines,
// runs the protocol engine and exposes the decoded control fields.
// Assumes the pad drives SDA low when sda_pull is 1 and otherwise releases it.
module lnb_ctl_i2c_slave
    import lnbi2c_pkg::*;
#(
    parameter int GLITCH_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic [1:0] dev_pin_a,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [4:0] fault_flags,
    output logic       tone_on,
    output logic       tone_mod_sel,
    output logic       tone_thr_sel,
    output logic       ilim_dynamic,
    output logic       vpin_sel_en,
    output logic [1:0] ilim_code,
    output logic       out_en,
    output logic       vrange_hi,
    output logic       vstep_up
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, clean_lines;
    logic              wr_stb;
    logic [7:0]        wr_byte;
    ctl_fields_t       fields;

    assign raw_lines = {sda_in, scl_in};

    // One filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        lnbi2c_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    lnbi2c_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok      (pwr_ok),
        .dev_pin_a   (dev_pin_a),
        .scl_f       (clean_lines[0]),
        .sda_f       (clean_lines[1]),
        .status_byte ({3'b000, fault_flags}),
        .sda_pull    (sda_pull),
        .wr_stb      (wr_stb),
        .wr_byte     (wr_byte)
    );

    lnbi2c_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_ok  (pwr_ok),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .fields  (fields)
    );

    // Unpack the control fields onto the ports.
    always_comb begin
        tone_on      = fields.tone_on;
        tone_mod_sel = fields.tone_mod_sel;
        tone_thr_sel = fields.tone_thr_sel;
        ilim_dynamic = fields.ilim_dynamic;
        vpin_sel_en  = fields.vpin_sel_en;
        ilim_code    = fields.ilim_code;
        out_en       = fields.out_en;
        vrange_hi    = fields.vrange_hi;
        vstep_up     = fields.vstep_up;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sda_pull && !out_en && !tone_on)); // R11

endmodule

// File: tb/tb_lnb_ctl_i2c_slave.sv
// Self-checking bench: bus master tasks, shadow register model, random writes
// and reads plus directed abort, glitch and power-gating cases.
module tb_lnb_ctl_i2c_slave;
    localparam int Q = 10;        // system clocks per quarter SCL period
    localparam int GLITCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b1;
    logic [1:0] pins = 2'b10;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [4:0] faults = '0;
    logic       tone_on, tone_mod_sel, tone_thr_sel, ilim_dynamic, vpin_sel_en;
    logic [1:0] ilim_code;
    logic       out_en, vrange_hi, vstep_up;
    wire        sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] sh_tone = '0, sh_lim = '0, sh_out = '0;

    always #2.5 clk = ~clk;

    lnb_ctl_i2c_slave #(.GLITCH_CYC(GLITCH)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .dev_pin_a(pins),
        .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .fault_flags(faults), .tone_on(tone_on), .tone_mod_sel(tone_mod_sel),
        .tone_thr_sel(tone_thr_sel), .ilim_dynamic(ilim_dynamic),
        .vpin_sel_en(vpin_sel_en), .ilim_code(ilim_code), .out_en(out_en),
        .vrange_hi(vrange_hi), .vstep_up(vstep_up)
    );

    function automatic logic [10:0] outs_now();
        return {tone_on, tone_mod_sel, tone_thr_sel, ilim_dynamic, vpin_sel_en,
                ilim_code, out_en, vrange_hi, vstep_up};
    endfunction

    function automatic logic [10:0] outs_exp();
        return {sh_tone[4:2], sh_lim[4:3], sh_lim[1:0], sh_out[4], sh_out[1:0]};
    endfunction

    task automatic model_write(input logic [7:0] b);
        case (b[7:5])
            3'b001: sh_tone = b[4:0];
            3'b010: sh_lim  = b[4:0];
            3'b011: sh_out  = b[4:0];
            default: ;
        endcase
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl = 1'b0;   waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(Q);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b1; waitc(Q);
    endtask

    task automatic clk_bit(input logic v, input logic glitch);
        sda_m = v; waitc(Q);
        if (glitch) begin
            scl = 1'b1; waitc(GLITCH - 2); scl = 1'b0; waitc(2);
        end
        scl = 1'b1; waitc(2 * Q);
        scl = 1'b0; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch);
        sda_m = 1'b1; waitc(Q);
        scl = 1'b1;   waitc(Q);
        ack = ~sda_line;
        waitc(Q);
        scl = 1'b0;   waitc(Q);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(Q); scl = 1'b1; waitc(Q);
            b[i] = sda_line;
            waitc(Q); scl = 1'b0; waitc(Q);
        end
        sda_m = ~m_ack; waitc(Q);
        scl = 1'b1; waitc(2 * Q);
        scl = 1'b0; waitc(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] addr_byte(input logic rd);
        return {5'b00010, pins, rd};
    endfunction

    // Write transfer of n bytes; every acknowledge is checked.
    task automatic write_xfer(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input int n);
        logic ack;
        logic [7:0] bl [3];
        bl[0] = b0; bl[1] = b1; bl[2] = b2;
        bus_start();
        send_byte(addr_byte(1'b0), 1'b0, ack);
        check(ack, "R1 address ack", int'(ack), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(bl[k], 1'b0, ack);
            check(ack, "R2 data ack", int'(ack), 1);
            model_write(bl[k]);
        end
        bus_stop();
        waitc(4);
    endtask

    initial begin : watchdog
        waitc(190000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        logic ack;
        logic [7:0] rb;
        void'($urandom(32'd7741));
        waitc(4);
        rst_n = 1'b1;
        waitc(4);

        // R11: reset state
        check(outs_now() == 11'd0, "R11 outputs after reset", outs_now(), 0);
        check(sda_pull == 1'b0, "R11 sda released", sda_pull, 0);

        // R3 R4 R5 directed field maps, R8 three bytes in one transfer
        write_xfer(8'b001_1_0_1_11, 8'b010_1_1_1_10, 8'b011_1_11_0_1, 3);
        check(outs_now() == outs_exp(), "R8 multi-byte write", outs_now(), outs_exp());
        check(tone_on && !tone_mod_sel && tone_thr_sel, "R3 tone fields",
              {tone_on, tone_mod_sel, tone_thr_sel}, 3'b101);
        check(ilim_dynamic && vpin_sel_en && ilim_code == 2'b10, "R4 limit fields",
              {ilim_dynamic, vpin_sel_en, ilim_code}, 4'b1110);
        check(out_en && !vrange_hi && vstep_up, "R5 output fields",
              {out_en, vrange_hi, vstep_up}, 3'b101);

        // R2 status select and 1xx selects change nothing
        write_xfer(8'b000_11111, 8'b111_00000, 8'b100_00000, 3);
        check(outs_now() == outs_exp(), "R2 ignored selects", outs_now(), outs_exp());

        // R1 wrong address is not acknowledged, write ignored
        bus_start();
        send_byte({5'b00010, ~pins, 1'b0}, 1'b0, ack);
        check(!ack, "R1 wrong address nack", int'(ack), 0);
        send_byte(8'b011_00000, 1'b0, ack);
        bus_stop(); waitc(4);
        check(outs_now() == outs_exp(), "R1 ignored after mismatch", outs_now(), outs_exp());

        // R2 R8 random multi-byte writes with random strap pins
        for (int t = 0; t < 40; t++) begin
            pins = 2'($urandom);
            write_xfer(8'($urandom), 8'($urandom), 8'($urandom), 1 + int'($urandom % 3));
            check(outs_now() == outs_exp(), "R2 random write", outs_now(), outs_exp());
        end

        // R6 reads under random fault patterns, two bytes then master nack
        for (int t = 0; t < 4; t++) begin
            faults = 5'($urandom);
            bus_start();
            send_byte(addr_byte(1'b1), 1'b0, ack);
            check(ack, "R1 read address ack", int'(ack), 1);
            recv_byte(1'b1, rb);
            check(rb == {3'b000, faults}, "R6 first read byte", rb, {3'b000, faults});
            recv_byte(1'b0, rb);
            check(rb == {3'b000, faults}, "R6 second read byte", rb, {3'b000, faults});
            waitc(2);
            check(sda_pull == 1'b0, "R6 released after master nack", sda_pull, 0);
            bus_stop(); waitc(4);
        end

        // R9 STOP after four bits of a byte
        bus_start();
        send_byte(addr_byte(1'b0), 1'b0, ack);
        clk_bit(1'b0, 1'b0); clk_bit(1'b1, 1'b0); clk_bit(1'b1, 1'b0); clk_bit(1'b0, 1'b0);
        bus_stop(); waitc(4);
        check(outs_now() == outs_exp(), "R9 stop mid-byte", outs_now(), outs_exp());

        // R9 repeated START after four bits, then a fresh transfer
        bus_start();
        send_byte(addr_byte(1'b0), 1'b0, ack);
        clk_bit(1'b0, 1'b0); clk_bit(1'b1, 1'b0); clk_bit(1'b1, 1'b0); clk_bit(1'b1, 1'b0);
        bus_start();
        send_byte(addr_byte(1'b0), 1'b0, ack);
        check(ack, "R9 address after restart", int'(ack), 1);
        send_byte(8'b010_0_1_0_01, 1'b0, ack);
        model_write(8'b010_0_1_0_01);
        bus_stop(); waitc(4);
        check(outs_now() == outs_exp(), "R9 restart mid-byte", outs_now(), outs_exp());

        // R10 short SCL spikes inside every low phase
        bus_start();
        send_byte(addr_byte(1'b0), 1'b1, ack);
        check(ack, "R10 address with spikes", int'(ack), 1);
        send_byte(8'b001_0_1_1_00, 1'b1, ack);
        model_write(8'b001_0_1_1_00);
        bus_stop(); waitc(4);
        check(outs_now() == outs_exp(), "R10 spikes rejected", outs_now(), outs_exp());

        // R7 power gating: no ack, outputs cleared, out_en starts at 0
        write_xfer(8'b011_10011, 8'h00, 8'h00, 1);
        pwr_ok = 1'b0; waitc(4);
        check(outs_now() == 11'd0, "R7 cleared while unpowered", outs_now(), 0);
        bus_start();
        send_byte(addr_byte(1'b0), 1'b0, ack);
        check(!ack, "R7 no ack while unpowered", int'(ack), 0);
        send_byte(8'b011_10000, 1'b0, ack);
        bus_stop(); waitc(4);
        check(outs_now() == 11'd0, "R7 write ignored while unpowered", outs_now(), 0);
        pwr_ok = 1'b1; waitc(4);
        sh_tone = '0; sh_lim = '0; sh_out = '0;
        check(out_en == 1'b0 && outs_now() == 11'd0, "R7 out_en after power good", outs_now(), 0);
        write_xfer(8'b011_10000, 8'h00, 8'h00, 1);
        check(outs_now() == outs_exp(), "R7 writable again", outs_now(), outs_exp());

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule